// File: doc/BRIEF.md
# Converter Serial Port Sequencer

This block is the digital serial port that sits between a host and the conversion core of a 12-bit sampling converter. The host uses three wires. A convert line starts a conversion and also gates the serial output. A shift clock moves the result out. A data-in line selects the input multiplexer setting for the next conversion. The block runs on a fast system clock. It synchronises the host lines into that clock, finds their edges there, and steps through four modes: idle, converting, sleeping and shifting.

On a rising convert edge the block sends a one-cycle start pulse to the core. It latches the parallel result when the core raises its done flag. If the convert line is still high at that point, the block reports sleep. When the convert line falls, the output is enabled and the MSB is presented at once. Each falling shift-clock edge then moves the next bit out, and zeros follow the LSB. The first two data-in bits of a frame are captured on rising shift-clock edges. They reach the mux configuration output at the next rising convert edge.

Top module: `adc_serial_port`

## Requirements
- R1: Every rising edge of conv_i produces exactly one start_o pulse, one system clock cycle wide.
- R2: sleep_o rises once done_i arrives while conv_i is high. It stays high until conv_i falls. It is low while converting before done_i.
- R3: sdo_oe_o is low while conv_i is high. It goes high after conv_i falls.
- R4: The latched result is sent MSB first. Bit 11 is on sdo_o as soon as the output is enabled. Each falling sck_i edge presents the next lower bit, so the host reads bit 11-k on rising edge k (counting from 0).
- R5: After bit 0 has been sent, every further falling sck_i edge with conv_i low keeps sdo_o at 0.
- R6: The first data-in bit of a frame, sampled on the first rising sck_i edge after conv_i falls, becomes mux_cfg_o[1] (single/differential select). The second becomes mux_cfg_o[0] (odd/sign select). mux_cfg_o changes only on the next rising conv_i edge.
- R7: sdi_i values on the third and later rising sck_i edges of a frame have no effect on mux_cfg_o.
- R8: A frame with fewer than two rising sck_i edges leaves mux_cfg_o unchanged at the next conversion.
- R9: The result is taken from result_i on the cycle done_i is high and passed as unipolar straight binary without recoding. Later changes on result_i do not change the bits shifted out.
- R10: After reset, sdo_oe_o, sleep_o and start_o are 0 and mux_cfg_o is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, several times faster than sck_i |
| rst_ni | input | 1 | Active-low asynchronous reset |
| conv_i | input | 1 | Host convert line: high starts conversion, low enables output |
| sck_i | input | 1 | Host shift clock |
| sdi_i | input | 1 | Host configuration data |
| result_i | input | 12 | Parallel result from the conversion core |
| done_i | input | 1 | Conversion-complete flag from the core |
| start_o | output | 1 | One-cycle start pulse to the core |
| sleep_o | output | 1 | Sleep indication |
| sdo_o | output | 1 | Serial data, valid while sdo_oe_o is high |
| sdo_oe_o | output | 1 | Output enable for the tri-state pad |
| mux_cfg_o | output | 2 | Mux configuration applied to the conversion |

## Verification
A host line change reaches the block's registered outputs on the third system clock edge after it. Two edges are spent in the synchroniser and one in the state register. The bench therefore drives every host change at a falling system clock edge and waits at least ten system cycles before it samples the effect. The shift clock has a half-period of ten system cycles, so each new sdo_o bit has settled well before the next rising sck_i edge, where the scoreboard monitor compares it. The start pulse is counted at every falling system edge. sleep_o and mux_cfg_o are checked forty cycles after the convert edge, which is well past the core model's done pulse at about twenty-three cycles.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [1:0] {
    M_IDLE  = 2'd0,
    M_CONV  = 2'd1,
    M_SLEEP = 2'd2,
    M_SHIFT = 2'd3
  } mode_e;
endpackage

// File: rtl/sp_edge_sync.sv
module sp_edge_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [STAGES:0] pipe;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe <= '0;
      else         pipe <= {pipe[STAGES-1:0], d_i[g]};
    end
    assign lvl_o[g]  = pipe[STAGES-1];
    assign rise_o[g] = pipe[STAGES-1] & ~pipe[STAGES];
    assign fall_o[g] = ~pipe[STAGES-1] & pipe[STAGES];
  end
endmodule

// File: rtl/sp_mode_ctrl.sv
module sp_mode_ctrl
  import sp_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         conv_lvl_i,
  input  logic         conv_rise_i,
  input  logic         conv_fall_i,
  input  logic         done_i,
  input  logic [W-1:0] result_i,
  output logic         start_o,
  output logic         sleep_o,
  output logic         oe_o,
  output logic [W-1:0] res_o
);
  mode_e mode_q;
  logic  start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= M_IDLE;
      start_q <= 1'b0;
      res_o   <= '0;
    end else begin
      start_q <= conv_rise_i;
      if (conv_fall_i)      mode_q <= M_SHIFT;
      else if (conv_rise_i) mode_q <= M_CONV;
      else if (mode_q == M_CONV && done_i) begin
        mode_q <= M_SLEEP;  // convert line still high: power down
        res_o  <= result_i;
      end
    end
  end

  assign start_o = start_q;
  assign sleep_o = (mode_q == M_SLEEP);
  assign oe_o    = (mode_q == M_SHIFT);

  p_start_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  p_sleep_conv_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_o |-> (conv_lvl_i || conv_fall_i));
  p_hiz_conv_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_o |-> (!conv_lvl_i || conv_rise_i));
endmodule

// File: rtl/sp_shift_out.sv
module sp_shift_out #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         shift_i,
  input  logic [W-1:0] data_i,
  output logic         bit_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  sh_q;
  logic [CW-1:0] sent_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      sent_q <= '0;
    end else if (load_i) begin
      sh_q   <= data_i;
      sent_q <= '0;
    end else if (shift_i) begin
      sh_q <= {sh_q[W-2:0], 1'b0};  // zero fill after LSB
      if (sent_q != CW'(W)) sent_q <= sent_q + 1'b1;
    end
  end

  assign bit_o = sh_q[W-1];

  p_zero_tail_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sent_q == CW'(W)) |-> !bit_o);
endmodule

// File: rtl/sp_cfg_capture.sv
module sp_cfg_capture #(
  parameter int CFG_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             conv_rise_i,
  input  logic             conv_fall_i,
  input  logic             sck_rise_i,
  input  logic             sdi_i,
  output logic [CFG_W-1:0] cfg_o
);
  localparam int NW = $clog2(CFG_W + 1);

  logic [NW-1:0]    n_q;
  logic [CFG_W-1:0] shadow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_q      <= '0;
      shadow_q <= '0;
      cfg_o    <= '0;
    end else begin
      if (conv_fall_i) n_q <= '0;
      else if (sck_rise_i && n_q != NW'(CFG_W)) begin
        shadow_q[CFG_W-1-int'(n_q)] <= sdi_i;  // first bit lands in MSB
        n_q <= n_q + 1'b1;
      end
      if (conv_rise_i && n_q == NW'(CFG_W)) cfg_o <= shadow_q;
    end
  end

  p_cfg_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !conv_rise_i |=> $stable(cfg_o));
  p_short_frame_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_rise_i && n_q != NW'(CFG_W)) |=> $stable(cfg_o));
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
  parameter int RES_W  = 12,
  parameter int CFG_W  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             conv_i,
  input  logic             sck_i,
  input  logic             sdi_i,
  input  logic [RES_W-1:0] result_i,
  input  logic             done_i,
  output logic             start_o,
  output logic             sleep_o,
  output logic             sdo_o,
  output logic             sdo_oe_o,
  output logic [CFG_W-1:0] mux_cfg_o
);
  localparam int I_CONV = 0;
  localparam int I_SCK  = 1;
  localparam int I_SDI  = 2;

  logic [2:0]       lvl, rise, fall;
  logic [RES_W-1:0] res_q;
  logic             sh_bit;

  sp_edge_sync #(.N(3), .STAGES(STAGES)) u_sync (
    .clk_i, .rst_ni,
    .d_i   ({sdi_i, sck_i, conv_i}),
    .lvl_o (lvl),
    .rise_o(rise),
    .fall_o(fall)
  );

  sp_mode_ctrl #(.W(RES_W)) u_ctrl (
    .clk_i, .rst_ni,
    .conv_lvl_i (lvl[I_CONV]),
    .conv_rise_i(rise[I_CONV]),
    .conv_fall_i(fall[I_CONV]),
    .done_i,
    .result_i,
    .start_o,
    .sleep_o,
    .oe_o       (sdo_oe_o),
    .res_o      (res_q)
  );

  sp_shift_out #(.W(RES_W)) u_shift (
    .clk_i, .rst_ni,
    .load_i (fall[I_CONV]),
    .shift_i(fall[I_SCK] & ~lvl[I_CONV]),
    .data_i (res_q),
    .bit_o  (sh_bit)
  );

  sp_cfg_capture #(.CFG_W(CFG_W)) u_cfg (
    .clk_i, .rst_ni,
    .conv_rise_i(rise[I_CONV]),
    .conv_fall_i(fall[I_CONV]),
    .sck_rise_i (rise[I_SCK] & ~lvl[I_CONV]),
    .sdi_i      (lvl[I_SDI]),
    .cfg_o      (mux_cfg_o)
  );

  assign sdo_o = sh_bit & sdo_oe_o;

  p_sdo_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sdo_oe_o |-> !sdo_o);
endmodule

// File: tb/sim_adc_serial_port.sv
`timescale 1ns/1ps
module sim_adc_serial_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv = 1'b0, sck = 1'b0, sdi = 1'b0, done = 1'b0;
  logic [11:0] result = '0;
  logic        start_o, sleep_o, sdo_o, sdo_oe_o;
  logic [1:0]  mux_cfg_o;

  int checks = 0, failures = 0, starts = 0;
  bit exp_q[$];
  int tag_q[$];
  bit finished = 0;

  always #2 clk = ~clk;

  adc_serial_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .conv_i(conv), .sck_i(sck), .sdi_i(sdi),
    .result_i(result), .done_i(done), .start_o(start_o), .sleep_o(sleep_o),
    .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .mux_cfg_o(mux_cfg_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // core model: done pulse twenty cycles after start
  initial forever begin
    @(negedge clk);
    if (start_o) begin
      cyc(20);
      done = 1'b1;
      cyc(1);
      done = 1'b0;
    end
  end

  initial forever begin
    @(negedge clk);
    if (start_o) starts++;
  end

  // scoreboard monitor: compare at each rising shift clock
  initial forever begin
    @(posedge sck);
    if (exp_q.size() == 0) chk(0, "R4 unexpected sck", 0, 0);
    else begin
      automatic bit e = exp_q.pop_front();
      automatic int t = tag_q.pop_front();
      chk(sdo_o == e, t == 5 ? "R5 zero tail" : "R4/R9 data bit", sdo_o, e);
      chk(sdo_oe_o, "R3 oe during frame", sdo_oe_o, 1);
    end
  end

  task automatic convert(input logic [11:0] res, input logic [1:0] exp_cfg);
    automatic int s0 = starts;
    result = res;
    conv = 1'b1;
    cyc(6);
    chk(!sleep_o, "R2 no sleep before done", sleep_o, 0);
    chk(!sdo_oe_o, "R3 hi-z while conv high", sdo_oe_o, 0);
    cyc(34);
    chk(starts - s0 == 1, "R1 one start pulse", starts - s0, 1);
    chk(sleep_o, "R2 sleep after done", sleep_o, 1);
    chk(!sdo_oe_o, "R3 hi-z in sleep", sdo_oe_o, 0);
    chk(mux_cfg_o == exp_cfg, "R6/R7/R8 cfg applied", mux_cfg_o, exp_cfg);
    result = ~res;  // R9: must not reach the output
  endtask

  task automatic frame(input logic [11:0] exp, input int nsck, input logic [15:0] pat,
                       input logic [1:0] cur_cfg);
    conv = 1'b0;
    cyc(20);
    chk(sdo_oe_o, "R3 oe after conv fall", sdo_oe_o, 1);
    chk(!sleep_o, "R2 sleep cleared", sleep_o, 0);
    for (int i = 0; i < nsck; i++) begin
      exp_q.push_back(i < 12 ? exp[11-i] : 1'b0);
      tag_q.push_back(i < 12 ? 4 : 5);
      sdi = pat[15-i];
      cyc(10);
      sck = 1'b1;
      cyc(10);
      sck = 1'b0;
    end
    cyc(10);
    chk(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
    chk(mux_cfg_o == cur_cfg, "R6 cfg held until conv rise", mux_cfg_o, cur_cfg);
  endtask

  initial begin
    cyc(3);
    chk(!sdo_oe_o, "R10 reset oe", sdo_oe_o, 0);
    chk(!sleep_o, "R10 reset sleep", sleep_o, 0);
    chk(!start_o, "R10 reset start", start_o, 0);
    chk(mux_cfg_o == 2'b00, "R10 reset cfg", mux_cfg_o, 0);
    rst_n = 1'b1;
    cyc(5);
    convert(12'hA5C, 2'b00);
    frame(12'hA5C, 16, 16'b1011_0000_0000_0000, 2'b00);  // R7: bits 3,4 ignored
    convert(12'h000, 2'b10);
    frame(12'h000, 14, 16'b0100_0000_0000_0000, 2'b10);
    convert(12'hFFF, 2'b01);
    frame(12'hFFF, 1, 16'b1000_0000_0000_0000, 2'b01);   // R8 short frame
    convert(12'h123, 2'b01);
    frame(12'h123, 13, 16'b1100_0000_0000_0000, 2'b01);
    convert(12'h800, 2'b11);
    frame(12'h800, 12, 16'h0000, 2'b11);
    conv = 1'b1;
    cyc(10);
    chk(!sdo_oe_o, "R3 hi-z after final rise", sdo_oe_o, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule